// File: doc/BRIEF.md
# Reloadable Programmable Clock Divider

This block divides a fast input clock by a software-chosen integer and drives one divided clock. Software reaches it through a small register port: a write strobe with 32-bit address and data, and combinational read data for the register at the current address. Two registers are decoded. The control word at address 0x0 holds the output enable and the reload handshake bits. The ratio word at address 0x8 holds the divide value waiting to be applied.

A ratio written to the ratio word does not change the output at once. It becomes active only after software writes the control word with both the output's reload-force flag and the global reload trigger set. That write latches the pending ratio. The divider switches at the next end of a complete output period, so no shortened pulse appears. Only the ratios 4, 5, 6 and 8 are accepted. When a reload carries any other value, the previous ratio stays in use. The enable is applied on period boundaries. A disabled output sits low.

Top module: `clkdiv_reload`

## Requirements
- R1: After a synchronous reset, the control word reads 0x00000000, the ratio word reads 0x00000400 (ratio 4 in bits [13:8]), and the divided clock is low.
- R2: The control word at address 0x0 reads back the last value written to it. Bit 25 is the output enable.
- R3: The ratio word at address 0x8 reads back the last value written to it. Its bits [13:8] hold the pending ratio. Writing it alone leaves the divided clock unchanged.
- R4: A reload is requested only by a write to the control word that has bit 1 (reload-force) and bit 8 (reload trigger) both set. A write with only one of the two bits set leaves the active ratio unchanged.
- R5: A requested reload replaces the active ratio at the end of the current output period, and every period of the output lasts exactly the active ratio in input cycles.
- R6: Within each period the output is high for floor(N/2) input cycles first and then low for the rest, for N = 4, 5, 6 and 8.
- R7: When the latched pending ratio is not 4, 5, 6 or 8, the reload is consumed and the previous active ratio is kept.
- R8: Clearing the reload-force and trigger bits after a reload leaves the active ratio unchanged.
- R9: With bit 25 clear, the output is low from the next period boundary on. Setting bit 25 restarts the output on a period boundary, with the high phase first.
- R10: Reads of any address other than 0x0 and 0x8 return zero. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 32 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at `addr` |
| div_clk | output | 1 | Divided, gated output clock |

## Verification
The divider is run at each legal ratio, including the odd ratio 5, and the high and low phase lengths are measured. This separates a wrong duty split from a wrong period. Reload attempts with only the force bit, with only the trigger bit, and with an illegal pending value of 7 or 3 are each shown to leave the previous waveform in place. A correct handshake switches the waveform, which shows that the gating logic separates these cases. The enable is toggled and the output is watched for silence and for a clean restart. A behavioural model predicts the output and the read data on every cycle, so a switch one cycle early or late is caught as well as a wrong final state.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned OUT_IDX   = 1;
    localparam int unsigned EN_BIT    = 24 + OUT_IDX;
    localparam int unsigned FORCE_BIT = OUT_IDX;
    localparam int unsigned TRIG_BIT  = 8;
    localparam int unsigned RATIO_LSB = 8;
    localparam int unsigned RATIO_W   = 6;

    localparam logic [BUS_W-1:0] CTRL_ADDR  = 32'h0000_0000;
    localparam logic [BUS_W-1:0] RATIO_ADDR = 32'h0000_0008;

    typedef logic [RATIO_W-1:0] ratio_t;

    localparam ratio_t RESET_RATIO = ratio_t'(4);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RATIO
    } reg_sel_e;

    typedef struct packed {
        logic   arm;
        ratio_t ratio;
    } reload_req_t;

    function automatic logic ratio_legal(input ratio_t r);
        return (r == ratio_t'(4)) || (r == ratio_t'(5)) ||
               (r == ratio_t'(6)) || (r == ratio_t'(8));
    endfunction

    function automatic ratio_t high_len(input ratio_t r);
        return r >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             enable,
    output reload_req_t      req
);

    logic [BUS_W-1:0] ctrl_q;
    logic [BUS_W-1:0] ratio_q;
    reg_sel_e         sel;

    always_comb begin
        sel = SEL_NONE;
        if (addr == CTRL_ADDR) begin
            sel = SEL_CTRL;
        end else if (addr == RATIO_ADDR) begin
            sel = SEL_RATIO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ratio_q <= BUS_W'(RESET_RATIO) << RATIO_LSB;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL:  ctrl_q  <= wdata;
                SEL_RATIO: ratio_q <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:  rdata = ctrl_q;
            SEL_RATIO: rdata = ratio_q;
            default:   rdata = '0;
        endcase
    end

    assign enable    = ctrl_q[EN_BIT];
    assign req.arm   = wr_en && (sel == SEL_CTRL) &&
                       wdata[FORCE_BIT] && wdata[TRIG_BIT];
    assign req.ratio = ratio_q[RATIO_LSB +: RATIO_W];

endmodule

// File: rtl/clkdiv_apply.sv
module clkdiv_apply
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  reload_req_t req,
    input  logic        boundary,
    output ratio_t      active,
    output logic        armed
);

    ratio_t staged_q;
    ratio_t active_q;
    logic   armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= RESET_RATIO;
            active_q <= RESET_RATIO;
            armed_q  <= 1'b0;
        end else begin
            if (boundary && armed_q) begin
                if (ratio_legal(staged_q)) begin
                    active_q <= staged_q;
                end
                armed_q <= 1'b0;
            end
            if (req.arm) begin
                armed_q  <= 1'b1;
                staged_q <= req.ratio;
            end
        end
    end

    assign active = active_q;
    assign armed  = armed_q;

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t active,
    input  logic   enable,
    output logic   boundary,
    output logic   run,
    output ratio_t count,
    output logic   div_out
);

    ratio_t cnt_q;
    logic   run_q;

    assign boundary = (cnt_q == active - ratio_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (boundary) begin
            cnt_q <= '0;
            run_q <= enable;
        end else begin
            cnt_q <= cnt_q + ratio_t'(1);
        end
    end

    assign run     = run_q;
    assign count   = cnt_q;
    assign div_out = run_q && (cnt_q < high_len(active));

endmodule

// File: rtl/clkdiv_reload.sv
module clkdiv_reload
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        div_clk
);

    logic        enable_w;
    reload_req_t req_w;
    logic        boundary_w;
    logic        run_w;
    logic        armed_w;
    ratio_t      active_w;
    ratio_t      count_w;

    clkdiv_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .enable (enable_w),
        .req    (req_w)
    );

    clkdiv_apply u_apply (
        .clk      (clk),
        .rst      (rst),
        .req      (req_w),
        .boundary (boundary_w),
        .active   (active_w),
        .armed    (armed_w)
    );

    clkdiv_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .active   (active_w),
        .enable   (enable_w),
        .boundary (boundary_w),
        .run      (run_w),
        .count    (count_w),
        .div_out  (div_clk)
    );

endmodule

// File: rtl/clkdiv_reload_chk.sv
module clkdiv_reload_chk
    import clkdiv_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   div_clk,
    input logic   run,
    input logic   boundary,
    input logic   armed,
    input ratio_t active,
    input ratio_t count
);

    p_legal_active_r7: assert property (@(posedge clk) disable iff (rst)
        ratio_legal(active));

    p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
        count < active);

    p_ratio_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!boundary || !armed) |=> $stable(active));

    p_low_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !run |-> !div_clk);

    p_run_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(run));

    p_high_first_r6: assert property (@(posedge clk) disable iff (rst)
        (run && count == '0) |-> div_clk);

endmodule

bind clkdiv_reload clkdiv_reload_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .div_clk  (div_clk),
    .run      (run_w),
    .boundary (boundary_w),
    .armed    (armed_w),
    .active   (active_w),
    .count    (count_w)
);

// File: tb/clkdiv_reload_tb_top.sv
module clkdiv_reload_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] addr = 32'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        div_clk;

    always #4 clk = ~clk;

    clkdiv_reload dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .div_clk (div_clk)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    localparam logic [31:0] EN   = 32'h0200_0000;
    localparam logic [31:0] FRC  = 32'h0000_0002;
    localparam logic [31:0] TRIG = 32'h0000_0100;

    // behavioural reference model
    int          m_cnt = 0, m_act = 4, m_staged = 4;
    bit          m_run = 0, m_armed = 0;
    logic [31:0] m_ctrl = 32'h0, m_ratio = 32'h400;

    function automatic bit legal(int r);
        return r == 4 || r == 5 || r == 6 || r == 8;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_act = 4; m_staged = 4;
            m_run = 0; m_armed = 0;
            m_ctrl = 32'h0; m_ratio = 32'h400;
        end else begin
            if (m_cnt == m_act - 1) begin
                if (m_armed && legal(m_staged)) m_act = m_staged;
                m_armed = 0;
                m_run = m_ctrl[25];
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            if (wr_en && addr == 32'h0) begin
                if (wdata[1] && wdata[8]) begin
                    m_armed = 1;
                    m_staged = int'(m_ratio[13:8]);
                end
                m_ctrl = wdata;
            end else if (wr_en && addr == 32'h8) begin
                m_ratio = wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model (R5 output timing, R2 read data)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5 per-cycle div_clk", {31'h0, div_clk},
                {31'h0, m_run && (m_cnt < m_act / 2)});
            chk("R2 per-cycle rdata", rdata,
                addr == 32'h0 ? m_ctrl : (addr == 32'h8 ? m_ratio : 32'h0));
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic measure(output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (div_clk !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
        while (div_clk !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        while (div_clk === 1'b1 && guard < 400) begin hi++; @(negedge clk); guard++; end
        while (div_clk === 1'b0 && guard < 400) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic reload(input int r);
        wr(32'h8, 32'(r) << 8);
        wr(32'h0, EN | FRC);
        wr(32'h0, EN | FRC | TRIG);
        wr(32'h0, EN);
    endtask

    task automatic expect_wave(input string tag, input int hi_e, input int lo_e);
        int hi, lo;
        measure(hi, lo);
        measure(hi, lo);
        chk({tag, " high"}, 32'(hi), 32'(hi_e));
        chk({tag, " low"}, 32'(lo), 32'(lo_e));
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hi, lo;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        rd(32'h0, d); chk("R1 ctrl reset", d, 32'h0);
        rd(32'h8, d); chk("R1 ratio reset", d, 32'h400);
        chk("R1 div_clk reset", {31'h0, div_clk}, 32'h0);

        wr(32'h0, EN);
        rd(32'h0, d); chk("R2 enable readback", d, EN);
        expect_wave("R6 ratio 4", 2, 2);

        wr(32'h8, 32'h500);
        rd(32'h8, d); chk("R3 ratio readback", d, 32'h500);
        expect_wave("R3 no effect before reload", 2, 2);

        wr(32'h0, EN | TRIG);
        expect_wave("R4 trigger alone", 2, 2);
        wr(32'h0, EN | FRC);
        expect_wave("R4 force alone", 2, 2);

        wr(32'h0, EN | FRC | TRIG);
        expect_wave("R5 switch to 5", 2, 3);
        wr(32'h0, EN);
        expect_wave("R8 clear keeps 5", 2, 3);

        reload(6); expect_wave("R6 ratio 6", 3, 3);
        reload(8); expect_wave("R6 ratio 8", 4, 4);
        reload(5); expect_wave("R6 ratio 5", 2, 3);
        reload(4); expect_wave("R5 back to 4", 2, 2);
        reload(8);
        reload(7); expect_wave("R7 ratio 7 rejected", 4, 4);
        reload(3); expect_wave("R7 ratio 3 rejected", 4, 4);

        wr(32'h0, 32'h0);
        repeat (10) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk) hi++;
        end
        chk("R9 disabled stays low", 32'(hi), 32'h0);
        wr(32'h0, EN);
        expect_wave("R9 restart", 4, 4);

        wr(32'h4, 32'hFFFF_FFFF);
        wr(32'h10, 32'hFFFF_FFFF);
        rd(32'h4, d); chk("R10 unmapped read", d, 32'h0);
        rd(32'h0, d); chk("R10 ctrl untouched", d, EN);
        rd(32'h8, d); chk("R10 ratio untouched", d, 32'h0000_0300);
        expect_wave("R10 wave untouched", 4, 4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule